// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of accepted cycles. It does not pass each word along a chain of flip-flops. Each word is written once into a two-port storage array and stays at that location. A write address counter and a read address counter step through the array together. Every accepted cycle stores one new word and reads back the word that was stored DEPTH accepted cycles before. For a long delay this uses one array plus two small counters, instead of DEPTH × DATA_W flip-flops that all toggle on every cycle.

The enable input makes the line elastic. On a cycle with enable low nothing is stored, neither counter moves, and the output holds its value. The delay is therefore counted in accepted cycles, not in clock cycles. After reset the array holds no meaningful data. A valid flag goes high once DEPTH words have been accepted and stays high until the next reset. DEPTH must be a power of two and at least 2.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `valid` and `dout` to zero, sets the read address to zero and sets the write address to all ones (DEPTH-1).
- R2: On each edge with `en` high and `rst_n` high, `din` is written at the current write address, and both addresses increase by one modulo DEPTH.
- R3: The read address always equals the write address plus one modulo DEPTH, so a read never targets the location being written.
- R4: The enabled edges are numbered j = 0, 1, 2, … from reset. The word accepted on enabled edge j appears on `dout` right after enabled edge j+DEPTH-1 (one cycle of read latency included). In other words, `dout` during the cycle that presents the m-th accepted word equals the word accepted DEPTH enables before it.
- R5: `valid` rises right after the DEPTH-th enabled edge following reset. It then stays high until a reset.
- R6: An edge with `en` low writes nothing and advances no address. `dout` and `valid` keep their values. A word accepted before a stall still comes out after exactly DEPTH-1 further enabled edges.
- R7: A reset in the middle of a stream restarts the line. `valid` stays low for the next DEPTH-1 enabled edges, and after that only words accepted since the reset appear while `valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Accept a word and advance the line this cycle |
| din | input | DATA_W | Word entering the line |
| dout | output | DATA_W | Word accepted DEPTH enables earlier |
| valid | output | 1 | High once DEPTH words have been accepted since reset |

## Verification
Every result is due right after an enabled rising edge. The word taken on enabled edge j is expected on `dout` after enabled edge j+DEPTH-1, and `valid` is expected after the DEPTH-th enabled edge. Edges with `en` low must leave both outputs unchanged. The bench drives inputs on the falling edge and samples one time unit after the rising edge. It keeps its own history of accepted words, indexed by the count of enabled edges, so stalls shift the expected arrival of each word by exactly the number of disabled cycles. The bench compares `dout` only while `valid` is expected high, and compares `valid` on every cycle.

// File: rtl/dly_pkg.sv
// Package: shared helpers for the memory-backed delay line.
// Assumes: depth values passed in are powers of two, at least 2.
package dly_pkg;

    // Address width needed to index a depth, never less than one bit.
    function automatic int unsigned addr_bits(input int unsigned depth);
        int unsigned w;
        w = $clog2(depth);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/dly_ptr_ctr.sv
// Module: address counter for one port of the storage array.
// Loads INIT on synchronous active-low reset and adds one on each
// enabled edge. It relies on a power-of-two depth, so the wrap from
// all ones to zero comes from the natural overflow of ADDR_W bits.
module dly_ptr_ctr #(
    parameter int unsigned ADDR_W = 4,
    parameter logic [ADDR_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);

    // Advance the address by one per accepted cycle, reset to INIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= INIT;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/dly_store.sv
// Module: storage array with one write port and one read port.
// The read is synchronous and gated by re, so the read register keeps
// its value on idle cycles. Only that register is reset; the array
// itself is not. It assumes the two addresses never match in a cycle
// where both ports are active.
module dly_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = dly_pkg::addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Write port: store the incoming word at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read port: register the addressed word; hold it on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/dly_fill_flag.sv
// Module: tells when the line has filled after reset.
// The read address starts at zero, so it reaches DEPTH-1 on the
// DEPTH-th accepted cycle. An accepted edge taken at that address is
// the DEPTH-th write, and the flag sets on that edge. Because the
// flag uses the read counter it needs no counter of its own.
module dly_fill_flag #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic              full
);

    localparam logic [ADDR_W-1:0] LAST = '1;

    // Set once the first full pass of the read address completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (step && rd_ptr == LAST) begin
            full <= 1'b1;
        end
    end

endmodule

// File: rtl/ram_delay_line.sv
// Module: fixed delay line whose data sits in a two-port array while
// the read and write addresses move.
// The write address starts at all ones and the read address at zero,
// so the read address is always one location ahead of the write
// address. Counting the read register, a word comes out DEPTH
// accepted cycles after it went in. The design assumes DEPTH is a
// power of two and at least 2, and uses a synchronous active-low
// reset.
module ram_delay_line #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);

    localparam int unsigned ADDR_W = dly_pkg::addr_bits(DEPTH);
    localparam logic [ADDR_W-1:0] WR_START = '1;
    localparam logic [ADDR_W-1:0] RD_START = '0;

    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic              accept;

    // Accept a word only when not in reset and enable is high.
    always_comb begin
        accept = rst_n && en;
    end

    dly_ptr_ctr #(.ADDR_W(ADDR_W), .INIT(WR_START)) u_wr_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .ptr   (wr_ptr)
    );

    dly_ptr_ctr #(.ADDR_W(ADDR_W), .INIT(RD_START)) u_rd_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .ptr   (rd_ptr)
    );

    dly_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .waddr (wr_ptr),
        .wdata (din),
        .re    (accept),
        .raddr (rd_ptr),
        .rdata (dout)
    );

    dly_fill_flag #(.ADDR_W(ADDR_W)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (accept),
        .rd_ptr (rd_ptr),
        .full   (valid)
    );

endmodule

// File: rtl/ram_delay_line_chk.sv
// Module: checker attached to the delay line with bind. It watches the
// two addresses and the outputs and raises an error if any timing
// property of the line is broken.
module ram_delay_line_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [DATA_W-1:0] dout,
    input logic              valid
);

    localparam logic [ADDR_W-1:0] ONE = 1;
    localparam logic [ADDR_W-1:0] TOP = '1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_ptr == '0 && wr_ptr == TOP && !valid && dout == '0));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (rd_ptr == $past(rd_ptr) + ONE && wr_ptr == $past(wr_ptr) + ONE));

    // R3
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr == wr_ptr + ONE);

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(en && rd_ptr == TOP));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(valid) && $stable(rd_ptr) && $stable(wr_ptr)));

endmodule

bind ram_delay_line ram_delay_line_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr),
    .dout   (dout),
    .valid  (valid)
);

// File: tb/sim_ram_delay_line.sv
// Bench: directed scenarios for the delay line, one task each. A queue
// of accepted words serves as the reference.
module sim_ram_delay_line;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W-1:0] hist[$];

    always #5 clk = ~clk;

    ram_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .din   (din),
        .dout  (dout),
        .valid (valid)
    );

    // Record one comparison and report it if it fails.
    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive on the falling edge, then check after the rising edge.
    task automatic step(input logic e, input logic [DATA_W-1:0] d, input string req);
        logic [DATA_W-1:0] prev_d;
        logic              prev_v;
        int                k;
        @(negedge clk);
        en = e;
        din = d;
        prev_d = dout;
        prev_v = valid;
        @(posedge clk);
        #1;
        if (e) begin
            hist.push_back(d);
            k = hist.size();
            check({req, " valid"}, {{(DATA_W-1){1'b0}}, valid},
                  {{(DATA_W-1){1'b0}}, (k >= DEPTH)});
            if (k >= DEPTH) check({req, " dout"}, dout, hist[k-DEPTH]);
        end else begin
            check({req, " R6 hold dout"}, dout, prev_d);
            check({req, " R6 hold valid"}, {{(DATA_W-1){1'b0}}, valid},
                  {{(DATA_W-1){1'b0}}, prev_v});
        end
    endtask

    // R1: apply reset and check the cleared outputs.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        din = 16'hdead;
        @(posedge clk);
        #1;
        check("R1 dout", dout, '0);
        check("R1 valid", {{(DATA_W-1){1'b0}}, valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;
        hist.delete();
    endtask

    // R4 R5: continuous stream over several wraps of the array.
    task automatic t_stream();
        for (int i = 0; i < 3 * DEPTH + 5; i++) begin
            step(1'b1, DATA_W'($urandom), "R4 R5 stream");
        end
    endtask

    // R2 R6: random stalls while the stream keeps flowing.
    task automatic t_stalls();
        for (int i = 0; i < 8 * DEPTH; i++) begin
            step(($urandom % 3) != 0, DATA_W'($urandom), "R2 R6 stalls");
        end
    endtask

    // R6: a long stall with changing din must not disturb the line.
    task automatic t_hold();
        for (int i = 0; i < DEPTH + 3; i++) begin
            step(1'b0, DATA_W'($urandom), "R6 long stall");
        end
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, DATA_W'(i * 3 + 1), "R6 after stall");
        end
    endtask

    // R7: reset in the middle of a stream restarts fill and delay.
    task automatic t_restart();
        for (int i = 0; i < DEPTH / 2; i++) begin
            step(1'b1, DATA_W'($urandom), "R7 pre");
        end
        t_reset();
        for (int i = 0; i < 2 * DEPTH; i++) begin
            step(i % 5 != 2, DATA_W'(16'h5000 + i), "R7 restart");
        end
    endtask

    initial begin
        t_reset();
        t_stream();
        t_stalls();
        t_hold();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: count an expired run as a failure and still summarise.
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule